// File: doc/BRIEF.md
# HDLC Receive Bit Destuffer and Flag Detector

This block sits behind a serial HDLC line interface and turns the raw received bit stream into data bytes. Bits arrive one at a time with a qualifying strobe. The block hunts for the opening flag octet (0x7E) and then strips the zero bits that the transmitter inserted after runs of five ones. It packs the surviving bits into bytes, first received bit in the least significant position. It keeps a running CRC-16 over every delivered data bit.

Each flag pulses a flag indication and presets the CRC. A run of seven ones inside a frame is an abort: it pulses an abort indication, drops the partial byte and returns the block to hunting. A control input chooses the byte framing:
- With alignment on, byte boundaries restart at every flag.
- With alignment off, the bit count runs on across flags.

Each raw bit passes through a short delay line, so the seven leading flag bits can be cancelled before they reach the byte packer. The flag pattern and a compare mask are parameters.

Top module: `hdlc_rx_destuff`

## Requirements
- R1: After reset, and in every cycle after a cycle with rx_en low, the three pulse outputs are 0 and crc_out is 0xFFFF. No flag, byte or abort is reported for bits offered while rx_en is low.
- R2: A cycle with bit_vld low has no effect, whatever the value on bit_in. It produces no pulse, and crc_out stays unchanged.
- R3: After enable, raw bits that arrive before the first flag are never delivered as data.
- R4: The raw bit sequence 0,1,1,1,1,1,1,0 raises flag_det for exactly one cycle, one clock after the last bit of the flag is accepted.
- R5: Inside a frame, a 0 that follows exactly five consecutive 1s is removed. It appears neither in a byte nor in the CRC.
- R6: Delivered bits fill rx_byte from bit 0 upward. rx_byte_vld is high for one cycle after the eighth delivered bit, and never in two consecutive cycles.
- R7: Flag bits are never delivered. Every data byte completed before a flag is reported before or without that flag's pulse, and never in the same cycle.
- R8: crc_out is the bit-serial CRC with polynomial x^16+x^12+x^5+1, shifted right with constant 0x8408 and no output inversion. When rx_byte_vld is high it covers every delivered bit since the last flag, through the last bit of that byte.
- R9: A flag presets the CRC, so crc_out reads 0xFFFF in the cycle flag_det is high.
- R10: A seventh consecutive 1 inside a frame raises abort_det for one cycle. The partial byte is dropped, and no data is delivered until the next flag.
- R11: With align_en high the bit count restarts at each flag. With align_en low, a byte may take bits from both sides of a flag.
- R12: Two flags that share a single 0 (0,1111110,1111110) are both detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; low clears the receiver |
| align_en | input | 1 | 1: byte count restarts at each flag |
| bit_vld | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Serial received bit |
| rx_byte | output | DATA_W | Last completed byte, first bit in bit 0 |
| rx_byte_vld | output | 1 | One-cycle strobe for rx_byte |
| flag_det | output | 1 | One-cycle pulse per detected flag |
| abort_det | output | 1 | One-cycle pulse per in-frame abort |
| crc_out | output | 16 | Running receive CRC |

## Verification
The main stimulus is a sweep of 256 two-byte frames covering every first-byte value. Odd values are sent with idle gaps that carry inverted bits. Values rich in ones exercise stuffed zeros at every bit offset, and the gaps separate ignored cycles from real bits. A frame of the standard nine-character check string pins the CRC to the known value 0x6F91. Directed cases cover the following:
- shared-zero flags;
- an abort after a partial byte, followed by hunting;
- a frame offered while disabled;
- a pair of half-byte runs across a flag with alignment off, which tells the two framing modes apart.

// File: rtl/hdlc_rx_pkg.sv
`timescale 1ns/1ps
package hdlc_rx_pkg;
    localparam int FLAG_W    = 8;
    localparam int CRC_W     = 16;
    localparam int STUFF_RUN = 5;
    localparam int ABORT_RUN = 7;
    localparam int RUN_W     = $clog2(ABORT_RUN + 1);

    // classification of the bit being accepted this cycle
    typedef enum logic [1:0] {
        BK_DATA  = 2'd0,
        BK_STUFF = 2'd1,
        BK_FLAG  = 2'd2,
        BK_ABORT = 2'd3
    } bit_kind_e;
endpackage

// File: rtl/hdlc_flag_scan.sv
`timescale 1ns/1ps
// Raw-bit window and ones-run tracker; classifies the incoming bit.
module hdlc_flag_scan
    import hdlc_rx_pkg::*;
#(
    parameter logic [FLAG_W-1:0] PAT  = 8'h7E,
    parameter logic [FLAG_W-1:0] MASK = 8'hFF
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      push,
    input  logic      bit_in,
    output bit_kind_e kind
);
    typedef struct packed {
        logic [FLAG_W-1:0] win;
        logic [RUN_W-1:0]  run;
    } scan_t;

    scan_t             s_d, s_q;
    logic [FLAG_W-1:0] cand;

    always_comb begin
        cand = {s_q.win[FLAG_W-2:0], bit_in};
        if ((cand & MASK) == (PAT & MASK))
            kind = BK_FLAG;
        else if (bit_in && s_q.run == RUN_W'(ABORT_RUN - 1))
            kind = BK_ABORT;
        else if (!bit_in && s_q.run == RUN_W'(STUFF_RUN))
            kind = BK_STUFF;
        else
            kind = BK_DATA;

        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else if (push) begin
            s_d.win = cand;
            if (!bit_in)
                s_d.run = '0;
            else if (s_q.run != RUN_W'(ABORT_RUN))
                s_d.run = s_q.run + RUN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/hdlc_bit_delay.sv
`timescale 1ns/1ps
// Delay line holding the most recent raw bits with a keep mark each,
// so a detected flag can cancel its own leading bits.
module hdlc_bit_delay #(
    parameter int DEPTH = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic push,
    input  logic bit_in,
    input  logic bit_ok,
    input  logic flush,
    output logic out_bit,
    output logic out_ok
);
    typedef struct packed {
        logic [DEPTH-1:0] dat;
        logic [DEPTH-1:0] ok;
    } dly_t;

    dly_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        if (clr) begin
            d_d = '0;
        end else if (push) begin
            d_d.dat = {d_q.dat[DEPTH-2:0], bit_in};
            d_d.ok  = flush ? '0 : {d_q.ok[DEPTH-2:0], bit_ok};
        end
        out_bit = d_q.dat[DEPTH-1];
        out_ok  = d_q.ok[DEPTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end
endmodule

// File: rtl/hdlc_crc_step.sv
`timescale 1ns/1ps
// One bit of a right-shifting CRC.
module hdlc_crc_step #(
    parameter int            W    = 16,
    parameter logic [W-1:0]  POLY = 16'h8408
) (
    input  logic [W-1:0] crc_in,
    input  logic         bit_in,
    output logic [W-1:0] crc_out
);
    always_comb begin
        crc_out = (crc_in >> 1) ^ ((crc_in[0] ^ bit_in) ? POLY : '0);
    end
endmodule

// File: rtl/hdlc_rx_destuff.sv
`timescale 1ns/1ps
module hdlc_rx_destuff
    import hdlc_rx_pkg::*;
#(
    parameter int               DATA_W    = 8,
    parameter logic [FLAG_W-1:0] FLAG_PAT  = 8'h7E,
    parameter logic [FLAG_W-1:0] FLAG_MASK = 8'hFF,
    parameter logic [CRC_W-1:0]  CRC_POLY  = 16'h8408,
    parameter logic [CRC_W-1:0]  CRC_INIT  = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              align_en,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_byte_vld,
    output logic              flag_det,
    output logic              abort_det,
    output logic [CRC_W-1:0]  crc_out
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam int DLY_D = FLAG_W - 1;

    typedef struct packed {
        logic              in_frame;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] byte_r;
        logic              byte_vld;
        logic              flag;
        logic              abort;
        logic [CRC_W-1:0]  crc;
    } rx_st_t;

    rx_st_t            st_d, st_q;
    bit_kind_e         kind;
    logic              push, clr, flush, keep;
    logic              dly_bit, dly_ok;
    logic [CRC_W-1:0]  crc_nx;
    logic [DATA_W-1:0] sh_nx;

    assign push  = rx_en & bit_vld;
    assign clr   = ~rx_en;
    assign flush = (kind == BK_FLAG) || (kind == BK_ABORT);
    assign keep  = (kind != BK_STUFF);

    hdlc_flag_scan #(.PAT(FLAG_PAT), .MASK(FLAG_MASK)) u_scan (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push(push),
        .bit_in(bit_in), .kind(kind)
    );

    hdlc_bit_delay #(.DEPTH(DLY_D)) u_dly (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push(push),
        .bit_in(bit_in), .bit_ok(keep), .flush(flush),
        .out_bit(dly_bit), .out_ok(dly_ok)
    );

    hdlc_crc_step #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .crc_in(st_q.crc), .bit_in(dly_bit), .crc_out(crc_nx)
    );

    always_comb begin
        sh_nx         = {dly_bit, st_q.sh[DATA_W-1:1]};
        st_d          = st_q;
        st_d.byte_vld = 1'b0;
        st_d.flag     = 1'b0;
        st_d.abort    = 1'b0;
        if (!rx_en) begin
            st_d.in_frame = 1'b0;
            st_d.cnt      = '0;
            st_d.sh       = '0;
            st_d.crc      = CRC_INIT;
        end else if (bit_vld) begin
            if (kind == BK_FLAG) begin
                st_d.in_frame = 1'b1;
                st_d.flag     = 1'b1;
                st_d.crc      = CRC_INIT;
                if (align_en) st_d.cnt = '0;
            end else if (kind == BK_ABORT) begin
                if (st_q.in_frame) begin
                    st_d.abort    = 1'b1;
                    st_d.in_frame = 1'b0;
                    st_d.cnt      = '0;
                end
            end else if (st_q.in_frame && dly_ok) begin
                st_d.crc = crc_nx;
                st_d.sh  = sh_nx;
                if (st_q.cnt == CNT_W'(DATA_W - 1)) begin
                    st_d.byte_r   = sh_nx;
                    st_d.byte_vld = 1'b1;
                    st_d.cnt      = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.crc <= CRC_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_byte     = st_q.byte_r;
    assign rx_byte_vld = st_q.byte_vld;
    assign flag_det    = st_q.flag;
    assign abort_det   = st_q.abort;
    assign crc_out     = st_q.crc;
endmodule

// File: rtl/hdlc_rx_destuff_chk.sv
`timescale 1ns/1ps
module hdlc_rx_destuff_chk #(
    parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_en,
    input logic        bit_vld,
    input logic        rx_byte_vld,
    input logic        flag_det,
    input logic        abort_det,
    input logic [15:0] crc_out
);
    // R1
    disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!rx_byte_vld && !flag_det && !abort_det && crc_out == CRC_INIT));

    // R2
    idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> (!rx_byte_vld && !flag_det && !abort_det));

    // R2
    idle_crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !bit_vld) |=> $stable(crc_out));

    // R4
    flag_from_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_det |-> ($past(bit_vld) && $past(rx_en)));

    // R6
    byte_strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_byte_vld |=> !rx_byte_vld);

    // R7
    flag_not_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_det, rx_byte_vld, abort_det}));

    // R9
    flag_crc_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_det |-> crc_out == CRC_INIT);

    // R10
    abort_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_det |=> (!abort_det && !rx_byte_vld));
endmodule

bind hdlc_rx_destuff hdlc_rx_destuff_chk #(.CRC_INIT(CRC_INIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_vld(bit_vld),
    .rx_byte_vld(rx_byte_vld), .flag_det(flag_det), .abort_det(abort_det),
    .crc_out(crc_out)
);

// File: tb/hdlc_rx_destuff_tb.sv
`timescale 1ns/1ps
module hdlc_rx_destuff_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic        align_en = 1'b1;
    logic        bit_vld = 1'b0;
    logic        bit_in = 1'b0;
    logic [7:0]  rx_byte;
    logic        rx_byte_vld, flag_det, abort_det;
    logic [15:0] crc_out;

    hdlc_rx_destuff u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .align_en(align_en),
        .bit_vld(bit_vld), .bit_in(bit_in), .rx_byte(rx_byte),
        .rx_byte_vld(rx_byte_vld), .flag_det(flag_det),
        .abort_det(abort_det), .crc_out(crc_out)
    );

    always #2 clk = ~clk;

    int n_vec = 0, n_bad = 0, cyc = 0;
    int got_flags = 0, got_aborts = 0, exp_flags = 0, exp_aborts = 0;
    logic [7:0]  exp_byte_q[$];
    logic [15:0] exp_crc_q[$];
    logic [15:0] m_crc = 16'hFFFF;
    logic [7:0]  m_sh = 8'h00;
    int          m_cnt = 0, g_ones = 0;
    bit          gap_mode = 1'b0;
    string       sect = "R3 hunt";

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        c  = c >> 1;
        if (fb) c = c ^ 16'h8408;
        return c;
    endfunction

    // output monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_byte_vld) begin
                if (exp_byte_q.size() == 0) begin
                    check(1'b0, "R1/R3/R10 stray byte", {24'd0, rx_byte}, 0);
                end else begin
                    check(rx_byte == exp_byte_q[0], {sect, " R5/R6 byte (R2 gaps)"},
                          {24'd0, rx_byte}, {24'd0, exp_byte_q[0]});
                    check(crc_out == exp_crc_q[0], {sect, " R8 crc"},
                          {16'd0, crc_out}, {16'd0, exp_crc_q[0]});
                    void'(exp_byte_q.pop_front());
                    void'(exp_crc_q.pop_front());
                end
            end
            if (flag_det) begin
                got_flags++;
                check(exp_byte_q.size() == 0, "R7 bytes pending at flag",
                      exp_byte_q.size(), 0);
                check(crc_out == 16'hFFFF, "R9 crc preset at flag",
                      {16'd0, crc_out}, 32'hFFFF);
            end
            if (abort_det) got_aborts++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic send_raw(input bit b);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
        if (gap_mode) begin
            @(negedge clk);
            bit_vld = 1'b0;
            bit_in  = ~b;
        end
    endtask

    task automatic raw_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_raw(v[i]);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        bit_vld = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic data_bit(input bit b);
        send_raw(b);
        m_crc = crc_bit(m_crc, b);
        m_sh  = {b, m_sh[7:1]};
        m_cnt++;
        if (m_cnt == 8) begin
            exp_byte_q.push_back(m_sh);
            exp_crc_q.push_back(m_crc);
            m_cnt = 0;
        end
        if (b) begin
            g_ones++;
            if (g_ones == 5) begin
                send_raw(1'b0);   // stuffed zero, R5
                g_ones = 0;
            end
        end else begin
            g_ones = 0;
        end
    endtask

    task automatic data_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) data_bit(v[i]);
    endtask

    task automatic flag();
        raw_byte(8'h7E);
        g_ones = 0;
        m_crc  = 16'hFFFF;
        if (align_en) m_cnt = 0;
        exp_flags++;
    endtask

    task automatic reenable();
        @(negedge clk);
        bit_vld = 1'b0;
        rx_en   = 1'b0;
        @(negedge clk);
        rx_en = 1'b1;
        m_cnt = 0;
        m_sh  = 8'h00;
        m_crc = 16'hFFFF;
        g_ones = 0;
    endtask

    int snap;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!rx_byte_vld && !flag_det && !abort_det, "R1 reset pulses",
              {29'd0, rx_byte_vld, flag_det, abort_det}, 0);
        check(crc_out == 16'hFFFF, "R1 reset crc", {16'd0, crc_out}, 32'hFFFF);

        // R1: a full frame while disabled is ignored
        raw_byte(8'h7E); raw_byte(8'h42); raw_byte(8'h7E);
        idle(4);
        check(got_flags == 0, "R1 flags while disabled", got_flags, 0);
        check(crc_out == 16'hFFFF, "R1 crc while disabled", {16'd0, crc_out}, 32'hFFFF);

        // R3: garbage before the opening flag is not delivered
        reenable();
        raw_byte(8'hA6);
        raw_byte(8'h9B);

        // main sweep, R2 gaps on odd values, R5 stuffing on ones-rich values
        sect = "R5 sweep";
        for (int v = 0; v < 256; v++) begin
            gap_mode = v[0];
            flag();
            data_byte(8'(v));
            data_byte(8'(v) ^ 8'h5A);
        end
        gap_mode = 1'b0;
        flag();
        data_byte(8'hFF); data_byte(8'hFF); data_byte(8'h7E); data_byte(8'hFF);
        flag();
        idle(4);

        // R8: known check string
        sect = "R8 check string";
        flag();
        for (int i = 0; i < 9; i++) data_byte(8'h31 + 8'(i));
        check(m_crc == 16'h6F91, "R8 model check value", {16'd0, m_crc}, 32'h6F91);
        flag();
        idle(4);

        // R12: two flags sharing one zero
        sect = "R12 shared zero";
        snap = got_flags;
        flag();
        for (int i = 0; i < 6; i++) send_raw(1'b1);
        send_raw(1'b0);
        exp_flags++;
        m_crc = 16'hFFFF; m_cnt = 0; g_ones = 0;
        data_byte(8'h81);
        flag();
        idle(4);
        check(got_flags - snap == 3, "R12 shared-zero flags", got_flags - snap, 3);

        // R10: abort after a partial byte, then hunt
        sect = "R10 abort";
        flag();
        data_byte(8'h3C);
        for (int i = 0; i < 4; i++) data_bit(1'b0);
        for (int i = 0; i < 7; i++) send_raw(1'b1);
        exp_aborts++;
        m_cnt = 0;
        for (int i = 0; i < 3; i++) send_raw(1'b1);
        raw_byte(8'h55);
        g_ones = 0;
        flag();
        data_byte(8'hC3);
        flag();
        idle(4);
        check(got_aborts == 1, "R10 abort count", got_aborts, 1);

        // R11: alignment off, a byte straddles a flag
        sect = "R11 align off";
        align_en = 1'b0;
        reenable();
        flag();
        data_bit(1); data_bit(0); data_bit(1); data_bit(0);
        flag();
        data_bit(1); data_bit(1); data_bit(0); data_bit(0);
        flag();
        data_byte(8'h96);
        flag();
        idle(4);
        check(exp_byte_q.size() == 0, "R11 straddled bytes drained", exp_byte_q.size(), 0);

        // R11: same pattern with alignment on yields no straddled byte
        sect = "R11 align on";
        align_en = 1'b1;
        reenable();
        flag();
        data_bit(1); data_bit(0); data_bit(1); data_bit(0);
        flag();
        data_bit(1); data_bit(1); data_bit(0); data_bit(0);
        flag();
        idle(20);

        check(got_flags == exp_flags, "R4 flag count", got_flags, exp_flags);
        check(got_aborts == exp_aborts, "R10 total aborts", got_aborts, exp_aborts);
        check(exp_byte_q.size() == 0, "R6 missing bytes", exp_byte_q.size(), 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule